// File: doc/BRIEF.md
# Microcontroller Low-Power Mode Controller

This block steps a small 8-bit microcontroller core between four power states: normal running, idle, power-down, and a wake phase that follows power-down. Software picks idle or power-down by writing two mode bits. The block then drives several enables from the current state: the core clock gate, the oscillator enable, the clock enable of the peripheral timer array, and a write block for internal RAM. It also decides when the address-latch and program-store strobes are forced, and the level they are forced to.

In idle the oscillator keeps running and only the core clock stops. Idle ends on a hardware reset or on any enabled interrupt. A reset that ends idle opens a short window in which writes to internal RAM are held off. The core may still run for up to two machine cycles in that window before its own reset sequence takes over. Power-down stops the oscillator. It ends on a hardware reset, or on a level-sensitive, enabled external interrupt pin going low. On both exits the block re-enables the oscillator and keeps the core clock gated until a stabilisation counter, loaded from a port, has run out. An interrupt exit also waits for the pin to return high. It then raises a one-cycle flag so that the core services that interrupt before it resumes.

Top module: `lpm_ctrl`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `state` is 0 (run). In that state `core_clk_en`, `osc_en` and `tmr_clk_en` are 1, and `ram_wr_block`, `pin_hold` and `int_wake` are 0.
- R2: `state` encodes run as 0, idle as 1, power-down as 2 and wake as 3. In run, a cycle with `mode_wr`=1 moves to power-down on the next cycle if `mode_pd`=1. Otherwise it moves to idle if `mode_idle`=1. When both bits are set, power-down wins.
- R3: In idle, `core_clk_en`=0, `osc_en`=1, `tmr_clk_en` follows `tmr_run_idle`, `pin_hold`=1 and `pin_level`=1.
- R4: In idle, `irq_pending`=1 returns to run on the next cycle and `ram_wr_block` stays 0.
- R5: In idle, `chip_rst`=1 returns to run on the next cycle. `ram_wr_block` is then 1 for exactly TAKEOVER_MC×CLK_PER_MC cycles (24 by default), starting with the first run cycle. `chip_rst` takes priority over `irq_pending`.
- R6: In power-down, `osc_en`, `core_clk_en` and `tmr_clk_en` are 0, `pin_hold`=1 and `pin_level`=0. `irq_pending` has no effect.
- R7: Power-down moves to wake only when some external pin i has `ext_pin_n[i]`=0, `ext_en[i]`=1 and `ext_edge[i]`=0 (0 = level-sensitive, 1 = edge). A pin that is low but disabled or edge-configured leaves the state in power-down.
- R8: In wake, `osc_en`=1, `core_clk_en`=0, `tmr_clk_en`=0 and `pin_level`=0. Wake lasts at least `stab_cycles`+1 cycles.
- R9: After an interrupt wake, the block returns to run only once the stabilisation count has run out and every pin that caused the wake is high again. `int_wake` is 1 for exactly the first run cycle.
- R10: `chip_rst`=1 in power-down moves to wake. That wake ends after exactly `stab_cycles`+1 cycles, whatever the pins are doing. It leaves `int_wake` and `ram_wr_block` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| chip_rst | input | 1 | Hardware reset request from the chip reset pin |
| mode_wr | input | 1 | Strobe for a write to the power-mode bits |
| mode_idle | input | 1 | Idle request bit of the write |
| mode_pd | input | 1 | Power-down request bit of the write |
| tmr_run_idle | input | 1 | 1 keeps the peripheral timer clock running in idle |
| irq_pending | input | 1 | Any enabled interrupt is requesting |
| ext_pin_n | input | N_EXT | External interrupt pins, active low, already synchronised |
| ext_en | input | N_EXT | Enable per external interrupt |
| ext_edge | input | N_EXT | Trigger type per pin: 1 edge, 0 level |
| stab_cycles | input | STAB_W | Oscillator stabilisation count in clock cycles |
| state | output | 2 | Current state code |
| core_clk_en | output | 1 | Core clock gate enable |
| osc_en | output | 1 | Oscillator enable |
| tmr_clk_en | output | 1 | Peripheral timer array clock enable |
| ram_wr_block | output | 1 | Blocks internal RAM writes |
| pin_hold | output | 1 | Forces the address-latch and program-store strobes |
| pin_level | output | 1 | Level those strobes are forced to |
| int_wake | output | 1 | One-cycle flag: power-down was left through an interrupt |

## Verification
The hardest case to reach from the ports is an interrupt wake in which the stabilisation count and the pin release arrive in different orders. The bench enters power-down through a mode write, then pulls a qualified pin low. In one run the pin is held low well past the count, so the exit must wait for the release. In the other run the pin is released at once, so the wake must still last the full count. The RAM-write window is checked by counting its cycles after a reset ends idle.

// File: rtl/lpm_pkg.sv
// Shared types of the low-power mode controller.
// Assumes the 2-bit state codes are read by other logic and must not move.
package lpm_pkg;
    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_IDLE = 2'd1,
        ST_PD   = 2'd2,
        ST_WAKE = 2'd3
    } lpm_state_e;

    typedef enum logic {
        SRC_INT = 1'b0,
        SRC_RST = 1'b1
    } wake_src_e;
endpackage

// File: rtl/lpm_wake_qual.sv
// Qualifies external pins as power-down wake sources and remembers which
// pins caused a wake. Assumes the pins are synchronised and active low.
module lpm_wake_qual #(
    parameter int N_EXT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EXT-1:0] pin_n,
    input  logic [N_EXT-1:0] en,
    input  logic [N_EXT-1:0] edge_sel,
    input  logic             capture,
    output logic             hit,
    output logic             released
);
    logic [N_EXT-1:0] hit_vec;
    logic [N_EXT-1:0] armed;
    logic [N_EXT-1:0] still_low;

    // Per pin: enabled, level-sensitive and low counts as a wake.
    for (genvar i = 0; i < N_EXT; i++) begin : g_pin
        assign hit_vec[i]   = en[i] & ~edge_sel[i] & ~pin_n[i];
        assign still_low[i] = armed[i] & ~pin_n[i];
    end

    assign hit      = |hit_vec;
    assign released = ~|still_low;

    // Latch the set of pins that started the wake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= '0;
        end else if (capture) begin
            armed <= hit_vec;
        end
    end
endmodule

// File: rtl/lpm_stab_cnt.sv
// Counts oscillator stabilisation cycles while the controller is waking.
// done rises in the wake cycle whose index equals limit (0-based).
module lpm_stab_cnt #(
    parameter int STAB_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_wake,
    input  logic [STAB_W-1:0] limit,
    output logic              done
);
    logic [STAB_W-1:0] cnt;

    // Clear outside wake, count up to the limit inside it.
    always_ff @(posedge clk) begin
        if (!rst_n || !in_wake) begin
            cnt <= '0;
        end else if (cnt != limit) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = in_wake && (cnt == limit);
endmodule

// File: rtl/lpm_guard.sv
// Holds the RAM write block for a fixed number of cycles after a start pulse.
// Models the window in which the core may still run before its reset.
module lpm_guard #(
    parameter int GUARD_CYC = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic block
);
    localparam int GW = $clog2(GUARD_CYC + 1);
    localparam logic [GW-1:0] GLOAD = GW'(GUARD_CYC);

    logic [GW-1:0] left;

    // Load on start, count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left <= '0;
        end else if (start) begin
            left <= GLOAD;
        end else if (left != '0) begin
            left <= left - 1'b1;
        end
    end

    assign block = (left != '0);
endmodule

// File: rtl/lpm_fsm.sv
// Power-state sequencer. It decides the transitions between run, idle,
// power-down and wake, the wake source, and the interrupt-wake flag.
// Assumes chip_rst is synchronous and that the core resets itself on it.
module lpm_fsm
    import lpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chip_rst,
    input  logic       mode_wr,
    input  logic       mode_idle,
    input  logic       mode_pd,
    input  logic       irq_pending,
    input  logic       wake_hit,
    input  logic       wake_released,
    input  logic       stab_done,
    output lpm_state_e state,
    output logic       capture,
    output logic       guard_start,
    output logic       int_wake
);
    lpm_state_e nxt;
    wake_src_e  src, src_nxt;
    logic       int_done;

    // Next-state and side-effect decisions.
    always_comb begin
        nxt         = state;
        src_nxt     = src;
        capture     = 1'b0;
        guard_start = 1'b0;
        int_done    = 1'b0;
        case (state)
            ST_RUN: begin
                if (mode_wr && mode_pd) begin
                    nxt = ST_PD;
                end else if (mode_wr && mode_idle) begin
                    nxt = ST_IDLE;
                end
            end
            ST_IDLE: begin
                if (chip_rst) begin
                    nxt         = ST_RUN;
                    guard_start = 1'b1;
                end else if (irq_pending) begin
                    nxt = ST_RUN;
                end
            end
            ST_PD: begin
                if (chip_rst) begin
                    nxt     = ST_WAKE;
                    src_nxt = SRC_RST;
                end else if (wake_hit) begin
                    nxt     = ST_WAKE;
                    src_nxt = SRC_INT;
                    capture = 1'b1;
                end
            end
            ST_WAKE: begin
                if (chip_rst) begin
                    src_nxt = SRC_RST;
                end
                if (stab_done) begin
                    if (src == SRC_RST || chip_rst) begin
                        nxt = ST_RUN;
                    end else if (wake_released) begin
                        nxt      = ST_RUN;
                        int_done = 1'b1;
                    end
                end
            end
            default: nxt = ST_RUN;
        endcase
    end

    // State, wake source and flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_RUN;
            src      <= SRC_RST;
            int_wake <= 1'b0;
        end else begin
            state    <= nxt;
            src      <= src_nxt;
            int_wake <= int_done;
        end
    end
endmodule

// File: rtl/lpm_ctrl.sv
// Top of the low-power mode controller. It joins the sequencer, the wake
// qualifier, the stabilisation counter and the RAM guard, and decodes
// the enables from the state. Block reset is synchronous, active low.
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int N_EXT       = 2,
    parameter int STAB_W      = 20,
    parameter int CLK_PER_MC  = 12,
    parameter int TAKEOVER_MC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_rst,
    input  logic              mode_wr,
    input  logic              mode_idle,
    input  logic              mode_pd,
    input  logic              tmr_run_idle,
    input  logic              irq_pending,
    input  logic [N_EXT-1:0]  ext_pin_n,
    input  logic [N_EXT-1:0]  ext_en,
    input  logic [N_EXT-1:0]  ext_edge,
    input  logic [STAB_W-1:0] stab_cycles,
    output logic [1:0]        state,
    output logic              core_clk_en,
    output logic              osc_en,
    output logic              tmr_clk_en,
    output logic              ram_wr_block,
    output logic              pin_hold,
    output logic              pin_level,
    output logic              int_wake
);
    localparam int GUARD_CYC = TAKEOVER_MC * CLK_PER_MC;

    lpm_state_e st;
    logic       capture, guard_start, wake_hit, wake_released, stab_done;

    lpm_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .chip_rst     (chip_rst),
        .mode_wr      (mode_wr),
        .mode_idle    (mode_idle),
        .mode_pd      (mode_pd),
        .irq_pending  (irq_pending),
        .wake_hit     (wake_hit),
        .wake_released(wake_released),
        .stab_done    (stab_done),
        .state        (st),
        .capture      (capture),
        .guard_start  (guard_start),
        .int_wake     (int_wake)
    );

    lpm_wake_qual #(.N_EXT(N_EXT)) u_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_n   (ext_pin_n),
        .en      (ext_en),
        .edge_sel(ext_edge),
        .capture (capture),
        .hit     (wake_hit),
        .released(wake_released)
    );

    lpm_stab_cnt #(.STAB_W(STAB_W)) u_stab (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_wake(st == ST_WAKE),
        .limit  (stab_cycles),
        .done   (stab_done)
    );

    lpm_guard #(.GUARD_CYC(GUARD_CYC)) u_guard (
        .clk  (clk),
        .rst_n(rst_n),
        .start(guard_start),
        .block(ram_wr_block)
    );

    // Decode the enables and pin levels from the state.
    always_comb begin
        core_clk_en = 1'b0;
        osc_en      = 1'b1;
        tmr_clk_en  = 1'b0;
        pin_hold    = 1'b1;
        pin_level   = 1'b0;
        case (st)
            ST_RUN: begin
                core_clk_en = 1'b1;
                tmr_clk_en  = 1'b1;
                pin_hold    = 1'b0;
            end
            ST_IDLE: begin
                tmr_clk_en = tmr_run_idle;
                pin_level  = 1'b1;
            end
            ST_PD: begin
                osc_en = 1'b0;
            end
            default: begin
            end
        endcase
    end

    assign state = st;
endmodule

// File: rtl/lpm_ctrl_chk.sv
// Assertion checker for lpm_ctrl, attached to it with bind.
module lpm_ctrl_chk
    import lpm_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] state,
    input logic       mode_wr,
    input logic       mode_pd,
    input logic       osc_en,
    input logic       core_clk_en,
    input logic       int_wake,
    input logic       ram_wr_block
);
    AST_PD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'd0 && mode_wr && mode_pd) |=> (state == 2'd2)); // R2
    AST_BLOCK_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_wr_block) |-> ($past(state) == 2'd1)); // R5
    AST_NO_CLK_WITHOUT_OSC: assert property (@(posedge clk) disable iff (!rst_n)
        core_clk_en |-> osc_en); // R6
    AST_WAKE_ONLY_FROM_PD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'd3 && $past(state) != 2'd3) |-> ($past(state) == 2'd2)); // R7
    AST_WAKE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'd3) |-> (!core_clk_en && osc_en)); // R8
    AST_INT_WAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        int_wake |-> ($past(state) == 2'd3 && state == 2'd0)); // R9
    AST_INT_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        int_wake |=> !int_wake); // R9
endmodule

bind lpm_ctrl lpm_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .state       (state),
    .mode_wr     (mode_wr),
    .mode_pd     (mode_pd),
    .osc_en      (osc_en),
    .core_clk_en (core_clk_en),
    .int_wake    (int_wake),
    .ram_wr_block(ram_wr_block)
);

// File: tb/test_lpm_ctrl.sv
// Directed bench for lpm_ctrl: one task per scenario.
module test_lpm_ctrl;
    logic        clk = 1'b0;
    logic        rst_n, chip_rst, mode_wr, mode_idle, mode_pd;
    logic        tmr_run_idle, irq_pending;
    logic [1:0]  ext_pin_n, ext_en, ext_edge;
    logic [19:0] stab_cycles;
    logic [1:0]  state;
    logic        core_clk_en, osc_en, tmr_clk_en, ram_wr_block;
    logic        pin_hold, pin_level, int_wake;

    int n_chk = 0;
    int n_bad = 0;

    lpm_ctrl i_lpm_ctrl (
        .clk(clk), .rst_n(rst_n), .chip_rst(chip_rst), .mode_wr(mode_wr),
        .mode_idle(mode_idle), .mode_pd(mode_pd), .tmr_run_idle(tmr_run_idle),
        .irq_pending(irq_pending), .ext_pin_n(ext_pin_n), .ext_en(ext_en),
        .ext_edge(ext_edge), .stab_cycles(stab_cycles), .state(state),
        .core_clk_en(core_clk_en), .osc_en(osc_en), .tmr_clk_en(tmr_clk_en),
        .ram_wr_block(ram_wr_block), .pin_hold(pin_hold),
        .pin_level(pin_level), .int_wake(int_wake)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Advance one clock and settle just after the edge.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; chip_rst = 1'b0; mode_wr = 1'b0; mode_idle = 1'b0;
        mode_pd = 1'b0; irq_pending = 1'b0; ext_pin_n = 2'b11;
        ext_en = 2'b11; ext_edge = 2'b00; tmr_run_idle = 1'b0;
        stab_cycles = 20'd5;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic write_mode(input logic idl, input logic pd);
        mode_wr = 1'b1; mode_idle = idl; mode_pd = pd;
        tick();
        mode_wr = 1'b0; mode_idle = 1'b0; mode_pd = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        tick();
        chk("R1 state in reset", state, 0);
        rst_n = 1'b1;
        tick();
        chk("R1 state", state, 0);
        chk("R1 core_clk_en", core_clk_en, 1);
        chk("R1 osc_en", osc_en, 1);
        chk("R1 tmr_clk_en", tmr_clk_en, 1);
        chk("R1 ram_wr_block", ram_wr_block, 0);
        chk("R1 pin_hold", pin_hold, 0);
        chk("R1 int_wake", int_wake, 0);
    endtask

    task automatic t_idle_irq();
        do_reset();
        tmr_run_idle = 1'b1;
        write_mode(1'b1, 1'b0);
        chk("R2 idle code", state, 1);
        chk("R3 core_clk_en", core_clk_en, 0);
        chk("R3 osc_en", osc_en, 1);
        chk("R3 tmr runs", tmr_clk_en, 1);
        chk("R3 pin_hold", pin_hold, 1);
        chk("R3 pin_level", pin_level, 1);
        tmr_run_idle = 1'b0;
        #1;
        chk("R3 tmr paused", tmr_clk_en, 0);
        tick();
        chk("R3 stays idle", state, 1);
        irq_pending = 1'b1;
        tick();
        irq_pending = 1'b0;
        chk("R4 back to run", state, 0);
        chk("R4 no ram block", ram_wr_block, 0);
    endtask

    task automatic t_idle_rst();
        int cnt = 0;
        do_reset();
        write_mode(1'b1, 1'b0);
        chip_rst = 1'b1; irq_pending = 1'b1;
        tick();
        chip_rst = 1'b0; irq_pending = 1'b0;
        chk("R5 run after reset", state, 0);
        for (int i = 0; i < 40; i++) begin
            if (ram_wr_block) cnt++;
            tick();
        end
        chk("R5 block cycles", cnt, 24);
    endtask

    task automatic t_both_bits();
        do_reset();
        write_mode(1'b1, 1'b1);
        chk("R2 pd wins", state, 2);
        chk("R6 osc_en", osc_en, 0);
        chk("R6 core_clk_en", core_clk_en, 0);
        chk("R6 tmr_clk_en", tmr_clk_en, 0);
        chk("R6 pin_hold", pin_hold, 1);
        chk("R6 pin_level", pin_level, 0);
        irq_pending = 1'b1;
        tick(); tick();
        irq_pending = 1'b0;
        chk("R6 irq ignored", state, 2);
        chk("R6 osc still off", osc_en, 0);
    endtask

    task automatic t_pd_qual();
        do_reset();
        write_mode(1'b0, 1'b1);
        ext_en = 2'b10; ext_edge = 2'b10; ext_pin_n = 2'b00;
        tick(); tick();
        chk("R7 disabled/edge pins ignored", state, 2);
        chk("R7 osc stays off", osc_en, 0);
        ext_pin_n = 2'b11; ext_en = 2'b11; ext_edge = 2'b00;
        tick();
        ext_pin_n = 2'b01;
        tick();
        chk("R7 level pin wakes", state, 3);
    endtask

    task automatic t_pd_int_long();
        do_reset();
        write_mode(1'b0, 1'b1);
        ext_pin_n = 2'b10;
        tick();
        chk("R7 enter wake", state, 3);
        chk("R8 osc_en", osc_en, 1);
        chk("R8 core_clk_en", core_clk_en, 0);
        chk("R8 tmr_clk_en", tmr_clk_en, 0);
        chk("R8 pin_level", pin_level, 0);
        for (int i = 0; i < 15; i++) tick();
        chk("R9 waits for pin", state, 3);
        ext_pin_n = 2'b11;
        tick();
        chk("R9 run after release", state, 0);
        chk("R9 int_wake set", int_wake, 1);
        tick();
        chk("R9 int_wake single", int_wake, 0);
    endtask

    task automatic t_pd_int_short();
        int cnt = 0;
        do_reset();
        stab_cycles = 20'd7;
        write_mode(1'b0, 1'b1);
        ext_pin_n = 2'b01;
        tick();
        ext_pin_n = 2'b11;
        for (int i = 0; i < 20; i++) begin
            if (state == 2'd3) cnt++;
            tick();
        end
        chk("R8 wake length", cnt, 8);
        chk("R9 back in run", state, 0);
    endtask

    task automatic t_pd_rst();
        int cnt = 0;
        int seen = 0;
        do_reset();
        write_mode(1'b0, 1'b1);
        chip_rst = 1'b1;
        tick();
        chip_rst = 1'b0;
        chk("R10 wake on reset", state, 3);
        ext_pin_n = 2'b00;
        for (int i = 0; i < 20; i++) begin
            if (state == 2'd3) cnt++;
            if (int_wake || ram_wr_block) seen++;
            tick();
        end
        ext_pin_n = 2'b11;
        chk("R10 wake length", cnt, 6);
        chk("R10 run", state, 0);
        chk("R10 no flags", seen, 0);
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        t_reset();
        t_idle_irq();
        t_idle_rst();
        t_both_bits();
        t_pd_qual();
        t_pd_int_long();
        t_pd_int_short();
        t_pd_rst();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule